// File: doc/BRIEF.md
# Buck Converter Fault Response Manager

This block sits between the comparators of a buck power stage and its gate logic. It takes fault and warning flags that have already been compared, and it decides three things. The first is whether the stage may switch. The second is whether either switch must be forced on or off. The third is when the power-good output is high. It moves the converter through five states: idle, soft-start ramp, regulation, hiccup wait and latched off. Each protective fault class has its own response setting, so a fault can shut the converter down for good, shut it down and retry, or be logged and otherwise ignored.

Every qualified event sets a sticky bit in a fault vector. An active-low alert line is driven from the sticky bits that are not masked. A clear strobe resets the vector. Output overvoltage has its own protective action: the high-side switch is turned off and the low-side switch is held on to discharge the output, until a negative-overcurrent event releases it.

Top module: `fault_resp_mgr`

## Requirements
- R1: After synchronous reset the block is idle and input-locked. hs_off=1, ls_off=1, ls_hold=0, pgood=0, alert_n=1 and fault_bits=0.
- R2: When enable=1 and the input lock is released, the block ramps for exactly max(cfg_ramp_cycles,1) cycles and then regulates. During the ramp, hs_off=0 and pgood=0. During regulation, pgood=1. pgood=1 is never seen with hs_off=1.
- R3: The four checks that track the output (tracking OV fault, OV warning, tracking UV fault, UV warning) are qualified only during regulation. The following are qualified during both ramp and regulation: thermal, overcurrent fault and warning, fixed OV and input OV.
- R4: Mode fields cfg_ov_mode and cfg_uv_mode use 0 for latch-off, 1 for hiccup restart, and 2 or 3 for ignore. An ignored fault only sets its status bit; switching and pgood are unchanged. cfg_ot_restart uses 0 for latch-off and 1 for restart.
- R5: Latch-off turns conversion off and pulls pgood low. The block stays off while enable stays high. It leaves only after enable goes low, and starts a new ramp only once enable is high again and the input lock is released.
- R6: Restart turns conversion off for exactly max(cfg_hiccup_cycles,1) cycles and then begins a new ramp. If the fault recurs, the count starts again.
- R7: A latch-off or restart caused by OV alone (tracking or fixed) gives hs_off=1 with ls_hold=1 and ls_off=0. A later evt_noc gives ls_hold=0 and ls_off=1 until the next start.
- R8: flt_oc during ramp or regulation holds the low side on (ls_hold=1) while the flag is high. Conversion continues and pgood is unaffected.
- R9: evt_noc during ramp or regulation forces the low side off (ls_off=1). It takes precedence over flt_oc, and pgood is unaffected.
- R10: The input lock sets when vin_below_off=1 and releases when vin_above_on=1 (below-off wins). While locked, the block shuts down to idle. It restarts by itself once the lock releases with enable high.
- R11: flt_vin_ov during ramp or regulation always latches off, whatever the mode fields say.
- R12: fault_bits map, from bit 0 to bit 10: thermal, OC fault, OC warning, negative OC, tracking OV, fixed OV, OV warning, tracking UV, UV warning, input lock entry, input OV. Bits are sticky until clear_faults. An event in the same cycle as clear_faults still sets its bit.
- R13: alert_n=0 exactly when some bit of fault_bits is set whose alert_mask bit is 0.
- R14: Warnings (wrn_oc, wrn_ov, wrn_uv) leave hs_off, ls_hold, ls_off and pgood unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable |
| vin_above_on | input | 1 | Input above turn-on threshold |
| vin_below_off | input | 1 | Input below turn-off threshold |
| flt_ot | input | 1 | Thermal shutdown flag |
| flt_oc | input | 1 | Low-side overcurrent fault flag |
| wrn_oc | input | 1 | Overcurrent warning flag |
| evt_noc | input | 1 | Negative overcurrent event |
| flt_ov_trk | input | 1 | Tracking output OV fault flag |
| flt_ov_fix | input | 1 | Fixed output OV fault flag |
| wrn_ov | input | 1 | Output OV warning flag |
| flt_uv_trk | input | 1 | Tracking output UV fault flag |
| wrn_uv | input | 1 | Output UV warning flag |
| flt_vin_ov | input | 1 | Input OV fault flag |
| cfg_ot_restart | input | 1 | Thermal response: 0 latch, 1 restart |
| cfg_ov_mode | input | 2 | Output OV response mode |
| cfg_uv_mode | input | 2 | Output UV response mode |
| cfg_ramp_cycles | input | RAMP_W | Soft-start length in cycles |
| cfg_hiccup_cycles | input | HIC_W | Hiccup wait in cycles |
| alert_mask | input | 11 | Per-bit alert mask, 1 blocks |
| clear_faults | input | 1 | Clear sticky fault bits |
| hs_off | output | 1 | Force high-side switch off |
| ls_hold | output | 1 | Force low-side switch on |
| ls_off | output | 1 | Force low-side switch off |
| pgood | output | 1 | Power good |
| alert_n | output | 1 | Active-low alert |
| fault_bits | output | 11 | Sticky fault and warning bits |

## Verification
A wrong sequencer state shows up at once on hs_off and pgood. A ramp or hiccup counter that is off by one changes the number of samples with hs_off low and pgood low after a start, or with hs_off high after a restart. That count is measured exactly. A bad qualification window or a sticky bit that is not held shows in fault_bits and alert_n on the cycle after the flag is sampled. A lost overvoltage hold shows in ls_hold and ls_off during the off period.

// File: rtl/frm_pkg.sv
package frm_pkg;

    localparam int NSRC = 11;

    localparam int B_OT    = 0;
    localparam int B_OC    = 1;
    localparam int B_OCW   = 2;
    localparam int B_NOC   = 3;
    localparam int B_OVT   = 4;
    localparam int B_OVF   = 5;
    localparam int B_OVW   = 6;
    localparam int B_UVT   = 7;
    localparam int B_UVW   = 8;
    localparam int B_LOCK  = 9;
    localparam int B_VINOV = 10;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RAMP   = 3'd1,
        ST_RUN    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_LATCH  = 3'd4
    } cstate_e;

    typedef struct packed {
        logic hs_off;
        logic ls_hold;
        logic ls_off;
    } gate_cmd_t;

    // mode field: 0 latch, 1 restart, 2/3 ignore
    function automatic logic mode_acts(input logic [1:0] m);
        return ~m[1];
    endfunction

    function automatic logic mode_latches(input logic [1:0] m);
        return (m == 2'd0);
    endfunction

    function automatic logic is_converting(input cstate_e s);
        return (s == ST_RAMP) || (s == ST_RUN);
    endfunction

    function automatic logic is_stopped_fault(input cstate_e s);
        return (s == ST_HICCUP) || (s == ST_LATCH);
    endfunction

endpackage

// File: rtl/frm_seq.sv
module frm_seq
    import frm_pkg::*;
#(
    parameter int RAMP_W = 8,
    parameter int HIC_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              vin_above_on,
    input  logic              vin_below_off,
    input  logic              flt_ot,
    input  logic              flt_ov_trk,
    input  logic              flt_ov_fix,
    input  logic              flt_uv_trk,
    input  logic              flt_vin_ov,
    input  logic              evt_noc,
    input  logic              cfg_ot_restart,
    input  logic [1:0]        cfg_ov_mode,
    input  logic [1:0]        cfg_uv_mode,
    input  logic [RAMP_W-1:0] cfg_ramp_cycles,
    input  logic [HIC_W-1:0]  cfg_hiccup_cycles,
    output cstate_e           state,
    output logic              locked,
    output logic              lock_evt,
    output logic              ovp_hold
);

    localparam int CNT_W = (RAMP_W > HIC_W) ? RAMP_W : HIC_W;
    localparam int CW1   = CNT_W + 1;

    cstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             locked_q;
    logic             ovp_q, rel_q;

    logic ov_hit, uv_hit, ov_act, uv_act;
    logic latch_req, restart_req, ovp_cause;
    logic ramp_done, hic_done;
    logic [CW1-1:0] cnt_inc, ramp_lim, hic_lim;

    // input lock with hysteresis
    always_ff @(posedge clk) begin
        if (rst)                locked_q <= 1'b1;
        else if (vin_below_off) locked_q <= 1'b1;
        else if (vin_above_on)  locked_q <= 1'b0;
    end

    assign lock_evt = ~locked_q & vin_below_off;

    // fault classification, tracking checks only in regulation
    always_comb begin
        ov_hit      = (flt_ov_trk & (st_q == ST_RUN)) | flt_ov_fix;
        uv_hit      = flt_uv_trk & (st_q == ST_RUN);
        ov_act      = ov_hit & mode_acts(cfg_ov_mode);
        uv_act      = uv_hit & mode_acts(cfg_uv_mode);
        latch_req   = flt_vin_ov
                    | (flt_ot & ~cfg_ot_restart)
                    | (ov_act & mode_latches(cfg_ov_mode))
                    | (uv_act & mode_latches(cfg_uv_mode));
        restart_req = (flt_ot & cfg_ot_restart)
                    | (ov_act & ~mode_latches(cfg_ov_mode))
                    | (uv_act & ~mode_latches(cfg_uv_mode));
        ovp_cause   = ov_act & ~(flt_ot | flt_vin_ov | uv_act);
    end

    always_comb begin
        cnt_inc  = CW1'(cnt_q) + CW1'(1);
        ramp_lim = (cfg_ramp_cycles == '0) ? CW1'(1) : CW1'(cfg_ramp_cycles);
        hic_lim  = (cfg_hiccup_cycles == '0) ? CW1'(1) : CW1'(cfg_hiccup_cycles);
        ramp_done = (cnt_inc >= ramp_lim);
        hic_done  = (cnt_inc >= hic_lim);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (enable && !locked_q) st_d = ST_RAMP;
            end
            ST_RAMP, ST_RUN: begin
                if (!enable || locked_q)              st_d = ST_IDLE;
                else if (latch_req)                   st_d = ST_LATCH;
                else if (restart_req)                 st_d = ST_HICCUP;
                else if (st_q == ST_RAMP && ramp_done) st_d = ST_RUN;
            end
            ST_HICCUP: begin
                if (!enable || locked_q) st_d = ST_IDLE;
                else if (hic_done)       st_d = ST_RAMP;
            end
            ST_LATCH: begin
                if (!enable) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (st_d != st_q)
            cnt_d = '0;
        else if (st_q == ST_RAMP || st_q == ST_HICCUP)
            cnt_d = cnt_q + CNT_W'(1);
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // overvoltage discharge hold and its release by negative current
    always_ff @(posedge clk) begin
        if (rst) begin
            ovp_q <= 1'b0;
            rel_q <= 1'b0;
        end else if (is_converting(st_q) && is_stopped_fault(st_d)) begin
            ovp_q <= ovp_cause;
            rel_q <= 1'b0;
        end else if (is_stopped_fault(st_d)) begin
            if (ovp_q && evt_noc) rel_q <= 1'b1;
        end else begin
            ovp_q <= 1'b0;
            rel_q <= 1'b0;
        end
    end

    assign state    = st_q;
    assign locked   = locked_q;
    assign ovp_hold = ovp_q & ~rel_q & is_stopped_fault(st_q);

endmodule

// File: rtl/frm_status.sv
module frm_status
    import frm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cstate_e         state,
    input  logic            ovp_hold,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] alert_mask,
    input  logic            clear_faults,
    output logic [NSRC-1:0] fault_bits,
    output logic            alert_n
);

    logic [NSRC-1:0] stat_q, qual;
    logic            conv, reg_run;

    assign conv    = is_converting(state);
    assign reg_run = (state == ST_RUN);

    always_comb begin
        qual          = '0;
        qual[B_OT]    = raw[B_OT]    & conv;
        qual[B_OC]    = raw[B_OC]    & conv;
        qual[B_OCW]   = raw[B_OCW]   & conv;
        qual[B_NOC]   = raw[B_NOC]   & (conv | ovp_hold);
        qual[B_OVT]   = raw[B_OVT]   & reg_run;
        qual[B_OVF]   = raw[B_OVF]   & conv;
        qual[B_OVW]   = raw[B_OVW]   & reg_run;
        qual[B_UVT]   = raw[B_UVT]   & reg_run;
        qual[B_UVW]   = raw[B_UVW]   & reg_run;
        qual[B_LOCK]  = raw[B_LOCK];
        qual[B_VINOV] = raw[B_VINOV] & conv;
    end

    always_ff @(posedge clk) begin
        if (rst)               stat_q <= '0;
        else if (clear_faults) stat_q <= qual;
        else                   stat_q <= stat_q | qual;
    end

    assign fault_bits = stat_q;
    assign alert_n    = ~|(stat_q & ~alert_mask);

endmodule

// File: rtl/frm_gate.sv
module frm_gate
    import frm_pkg::*;
(
    input  cstate_e   state,
    input  logic      ovp_hold,
    input  logic      flt_oc,
    input  logic      evt_noc,
    output gate_cmd_t cmd,
    output logic      pgood
);

    always_comb begin
        if (is_converting(state)) begin
            cmd.hs_off  = 1'b0;
            cmd.ls_off  = evt_noc;
            cmd.ls_hold = flt_oc & ~evt_noc;
        end else begin
            cmd.hs_off  = 1'b1;
            cmd.ls_hold = ovp_hold;
            cmd.ls_off  = ~ovp_hold;
        end
        pgood = (state == ST_RUN);
    end

endmodule

// File: rtl/fault_resp_mgr.sv
module fault_resp_mgr
    import frm_pkg::*;
#(
    parameter int RAMP_W = 8,
    parameter int HIC_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              vin_above_on,
    input  logic              vin_below_off,
    input  logic              flt_ot,
    input  logic              flt_oc,
    input  logic              wrn_oc,
    input  logic              evt_noc,
    input  logic              flt_ov_trk,
    input  logic              flt_ov_fix,
    input  logic              wrn_ov,
    input  logic              flt_uv_trk,
    input  logic              wrn_uv,
    input  logic              flt_vin_ov,
    input  logic              cfg_ot_restart,
    input  logic [1:0]        cfg_ov_mode,
    input  logic [1:0]        cfg_uv_mode,
    input  logic [RAMP_W-1:0] cfg_ramp_cycles,
    input  logic [HIC_W-1:0]  cfg_hiccup_cycles,
    input  logic [10:0]       alert_mask,
    input  logic              clear_faults,
    output logic              hs_off,
    output logic              ls_hold,
    output logic              ls_off,
    output logic              pgood,
    output logic              alert_n,
    output logic [10:0]       fault_bits
);

    cstate_e         st;
    logic            locked, lock_evt, ovp_hold;
    logic [NSRC-1:0] raw;
    gate_cmd_t       cmd;

    frm_seq #(.RAMP_W(RAMP_W), .HIC_W(HIC_W)) u_seq (
        .clk(clk), .rst(rst), .enable(enable),
        .vin_above_on(vin_above_on), .vin_below_off(vin_below_off),
        .flt_ot(flt_ot), .flt_ov_trk(flt_ov_trk), .flt_ov_fix(flt_ov_fix),
        .flt_uv_trk(flt_uv_trk), .flt_vin_ov(flt_vin_ov), .evt_noc(evt_noc),
        .cfg_ot_restart(cfg_ot_restart), .cfg_ov_mode(cfg_ov_mode),
        .cfg_uv_mode(cfg_uv_mode), .cfg_ramp_cycles(cfg_ramp_cycles),
        .cfg_hiccup_cycles(cfg_hiccup_cycles),
        .state(st), .locked(locked), .lock_evt(lock_evt), .ovp_hold(ovp_hold)
    );

    always_comb begin
        raw          = '0;
        raw[B_OT]    = flt_ot;
        raw[B_OC]    = flt_oc;
        raw[B_OCW]   = wrn_oc;
        raw[B_NOC]   = evt_noc;
        raw[B_OVT]   = flt_ov_trk;
        raw[B_OVF]   = flt_ov_fix;
        raw[B_OVW]   = wrn_ov;
        raw[B_UVT]   = flt_uv_trk;
        raw[B_UVW]   = wrn_uv;
        raw[B_LOCK]  = lock_evt;
        raw[B_VINOV] = flt_vin_ov;
    end

    frm_status u_stat (
        .clk(clk), .rst(rst), .state(st), .ovp_hold(ovp_hold), .raw(raw),
        .alert_mask(alert_mask), .clear_faults(clear_faults),
        .fault_bits(fault_bits), .alert_n(alert_n)
    );

    frm_gate u_gate (
        .state(st), .ovp_hold(ovp_hold), .flt_oc(flt_oc), .evt_noc(evt_noc),
        .cmd(cmd), .pgood(pgood)
    );

    assign hs_off  = cmd.hs_off;
    assign ls_hold = cmd.ls_hold;
    assign ls_off  = cmd.ls_off;

endmodule

// File: rtl/frm_checker.sv
module frm_checker
    import frm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        flt_oc,
    input logic        evt_noc,
    input logic        flt_vin_ov,
    input logic        clear_faults,
    input logic        hs_off,
    input logic        ls_hold,
    input logic        ls_off,
    input logic        pgood,
    input logic [10:0] fault_bits,
    input cstate_e     st,
    input logic        locked
);

    a_r2_pgood_needs_switching: assert property (@(posedge clk) disable iff (rst)
        pgood |-> !hs_off);

    a_r3_ramp_ignores_tracking_ov: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RAMP && !clear_faults) |=> (fault_bits[B_OVT] == $past(fault_bits[B_OVT])));

    a_r5_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LATCH && enable) |=> (st == ST_LATCH));

    a_r8_oc_holds_low_side: assert property (@(posedge clk) disable iff (rst)
        (flt_oc && !evt_noc && !hs_off) |-> ls_hold);

    a_r9_noc_blocks_low_side: assert property (@(posedge clk) disable iff (rst)
        (evt_noc && !hs_off) |-> (ls_off && !ls_hold));

    a_r11_vin_ov_latches: assert property (@(posedge clk) disable iff (rst)
        (flt_vin_ov && (st == ST_RAMP || st == ST_RUN) && enable && !locked)
        |=> (st == ST_LATCH));

    a_r12_bits_sticky: assert property (@(posedge clk) disable iff (rst)
        !clear_faults |=> ((fault_bits & $past(fault_bits)) == $past(fault_bits)));

endmodule

bind fault_resp_mgr frm_checker u_chk (
    .clk(clk), .rst(rst), .enable(enable), .flt_oc(flt_oc), .evt_noc(evt_noc),
    .flt_vin_ov(flt_vin_ov), .clear_faults(clear_faults), .hs_off(hs_off),
    .ls_hold(ls_hold), .ls_off(ls_off), .pgood(pgood), .fault_bits(fault_bits),
    .st(st), .locked(locked)
);

// File: tb/sim_fault_resp_mgr.sv
`timescale 1ns/1ps
module sim_fault_resp_mgr;

    localparam int RAMP_N = 4;
    localparam int HIC_N  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 0, vin_above_on = 0, vin_below_off = 0;
    logic flt_ot = 0, flt_oc = 0, wrn_oc = 0, evt_noc = 0;
    logic flt_ov_trk = 0, flt_ov_fix = 0, wrn_ov = 0, flt_uv_trk = 0, wrn_uv = 0, flt_vin_ov = 0;
    logic cfg_ot_restart = 0;
    logic [1:0] cfg_ov_mode = 0, cfg_uv_mode = 0;
    logic [7:0] cfg_ramp_cycles = 8'(RAMP_N);
    logic [9:0] cfg_hiccup_cycles = 10'(HIC_N);
    logic [10:0] alert_mask = '0;
    logic clear_faults = 0;
    logic hs_off, ls_hold, ls_off, pgood, alert_n;
    logic [10:0] fault_bits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fault_resp_mgr u0 (
        .clk(clk), .rst(rst), .enable(enable), .vin_above_on(vin_above_on),
        .vin_below_off(vin_below_off), .flt_ot(flt_ot), .flt_oc(flt_oc),
        .wrn_oc(wrn_oc), .evt_noc(evt_noc), .flt_ov_trk(flt_ov_trk),
        .flt_ov_fix(flt_ov_fix), .wrn_ov(wrn_ov), .flt_uv_trk(flt_uv_trk),
        .wrn_uv(wrn_uv), .flt_vin_ov(flt_vin_ov), .cfg_ot_restart(cfg_ot_restart),
        .cfg_ov_mode(cfg_ov_mode), .cfg_uv_mode(cfg_uv_mode),
        .cfg_ramp_cycles(cfg_ramp_cycles), .cfg_hiccup_cycles(cfg_hiccup_cycles),
        .alert_mask(alert_mask), .clear_faults(clear_faults),
        .hs_off(hs_off), .ls_hold(ls_hold), .ls_off(ls_off), .pgood(pgood),
        .alert_n(alert_n), .fault_bits(fault_bits)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // number of samples in ramp (switching, pgood low) before pgood rises
    task automatic run_up(output int ramp_n);
        ramp_n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pgood) break;
            if (!hs_off) ramp_n++;
        end
    endtask

    task automatic clear_all();
        clear_faults = 1;
        tick(1);
        clear_faults = 0;
    endtask

    task automatic restart_enable(output int rn);
        enable = 0;
        tick(2);
        enable = 1;
        run_up(rn);
    endtask

    // expected next sticky vector from port-visible state
    function automatic logic [10:0] exp_next(input logic [10:0] cur, input logic clr,
                                             input logic on, input logic run, input logic hold,
                                             input logic [10:0] flags);
        logic [10:0] q;
        q = '0;
        q[0]  = flags[0] & on;
        q[1]  = flags[1] & on;
        q[2]  = flags[2] & on;
        q[3]  = flags[3] & (on | hold);
        q[4]  = flags[4] & run;
        q[5]  = flags[5] & on;
        q[6]  = flags[6] & run;
        q[7]  = flags[7] & run;
        q[8]  = flags[8] & run;
        q[10] = flags[10] & on;
        return clr ? q : (cur | q);
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rn, n;
        logic [10:0] expv;
        void'($urandom(32'd1234));

        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk(hs_off && ls_off && !ls_hold && !pgood && alert_n && fault_bits == 0,
            "R1 reset", {hs_off, ls_off, ls_hold, pgood, alert_n}, 5'b11001);

        // R2/R3 start-up with tracking flags held during the ramp
        vin_above_on = 1;
        enable = 1;
        rn = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pgood) break;
            if (!hs_off) begin
                rn++;
                flt_ov_trk = 1; wrn_ov = 1; flt_uv_trk = 1; wrn_uv = 1;
            end
        end
        flt_ov_trk = 0; wrn_ov = 0; flt_uv_trk = 0; wrn_uv = 0;
        chk(rn == RAMP_N, "R2 ramp length", rn, RAMP_N);
        chk(pgood == 1, "R2 pgood after ramp", pgood, 1);
        chk(fault_bits == 0, "R3 tracking ignored in ramp", fault_bits, 0);

        // R14/R12/R13 warnings
        wrn_oc = 1; wrn_ov = 1; wrn_uv = 1;
        tick(1);
        wrn_oc = 0; wrn_ov = 0; wrn_uv = 0;
        chk(pgood && !hs_off && !ls_hold && !ls_off, "R14 warnings no action",
            {pgood, hs_off, ls_hold, ls_off}, 4'b1000);
        chk(fault_bits == 11'b001_0100_0100, "R12 warning bits", fault_bits, 11'b001_0100_0100);
        tick(3);
        chk(fault_bits == 11'b001_0100_0100, "R12 bits sticky", fault_bits, 11'b001_0100_0100);
        chk(alert_n == 0, "R13 alert low", alert_n, 0);
        clear_all();
        chk(fault_bits == 0 && alert_n, "R12 clear", fault_bits, 0);
        alert_mask = 11'b000_0000_0100;
        wrn_oc = 1;
        tick(1);
        wrn_oc = 0;
        chk(fault_bits == 11'b100 && alert_n == 1, "R13 masked source", alert_n, 1);
        alert_mask = 0;
        tick(1);
        chk(alert_n == 0, "R13 unmask asserts", alert_n, 0);
        clear_all();

        // R8 low-side overcurrent
        flt_oc = 1;
        tick(3);
        chk(ls_hold && pgood && !hs_off, "R8 oc hold", {ls_hold, pgood}, 3);
        flt_oc = 0;
        tick(1);
        chk(!ls_hold && pgood, "R8 oc release", ls_hold, 0);

        // R9 negative overcurrent
        evt_noc = 1; flt_oc = 1;
        tick(1);
        chk(ls_off && !ls_hold && pgood, "R9 noc off", {ls_off, ls_hold, pgood}, 3'b101);
        evt_noc = 0; flt_oc = 0;
        tick(1);
        chk(!ls_off, "R9 noc release", ls_off, 0);
        clear_all();

        // R4 ignore mode
        cfg_ov_mode = 2;
        flt_ov_trk = 1;
        tick(1);
        flt_ov_trk = 0;
        tick(5);
        chk(pgood && fault_bits[4], "R4 ignore keeps running", {pgood, fault_bits[4]}, 3);

        // R6 restart with exact hiccup length
        cfg_uv_mode = 1;
        flt_uv_trk = 1;
        tick(1);
        flt_uv_trk = 0;
        chk(hs_off && ls_off && !pgood, "R6 restart turns off", {hs_off, ls_off, pgood}, 3'b110);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!hs_off) break;
            n++;
        end
        chk(n == HIC_N, "R6 hiccup length", n, HIC_N);

        // R3 thermal active during ramp, R5 latch-off
        cfg_ot_restart = 0;
        flt_ot = 1;
        tick(1);
        flt_ot = 0;
        chk(hs_off && !pgood && fault_bits[0], "R3 thermal in ramp", {hs_off, pgood}, 2);
        tick(40);
        chk(hs_off && !pgood, "R5 latch stays off", hs_off, 1);
        restart_enable(rn);
        chk(pgood && rn == RAMP_N, "R5 re-enable restarts", rn, RAMP_N);
        clear_all();

        // R7 fixed OV latch holds low side until negative current
        cfg_ov_mode = 0;
        flt_ov_fix = 1;
        tick(1);
        flt_ov_fix = 0;
        tick(4);
        chk(hs_off && ls_hold && !ls_off && !pgood, "R7 ov discharge",
            {hs_off, ls_hold, ls_off, pgood}, 4'b1100);
        evt_noc = 1;
        tick(1);
        evt_noc = 0;
        tick(2);
        chk(hs_off && !ls_hold && ls_off, "R7 noc release", {ls_hold, ls_off}, 1);
        restart_enable(rn);
        clear_all();

        // R11 input OV latches regardless of modes
        cfg_ot_restart = 1; cfg_ov_mode = 1; cfg_uv_mode = 1;
        flt_vin_ov = 1;
        tick(1);
        flt_vin_ov = 0;
        tick(HIC_N + RAMP_N + 10);
        chk(hs_off && !pgood && fault_bits[10], "R11 vin ov latched", hs_off, 1);
        restart_enable(rn);
        clear_all();

        // R10 input lock with hysteresis
        vin_above_on = 0;
        vin_below_off = 1;
        tick(1);
        vin_below_off = 0;
        tick(2);
        chk(hs_off && !pgood && fault_bits[9], "R10 lock shuts down", fault_bits[9], 1);
        tick(10);
        chk(hs_off, "R10 stays locked", hs_off, 1);
        vin_above_on = 1;
        run_up(rn);
        chk(pgood && rn == RAMP_N, "R10 auto restart", rn, RAMP_N);
        clear_all();

        // R12 set wins over clear
        wrn_uv = 1; tick(1);
        wrn_uv = 0; wrn_ov = 1; clear_faults = 1;
        tick(1);
        wrn_ov = 0; clear_faults = 0;
        chk(fault_bits == 11'b000_0100_0000, "R12 set wins over clear", fault_bits, 11'b000_0100_0000);
        clear_all();

        // random phase: sticky bits and alert against bench model
        cfg_ramp_cycles = 8'd3;
        cfg_hiccup_cycles = 10'd5;
        expv = fault_bits;
        for (int c = 0; c < 3000; c++) begin
            logic [10:0] fl;
            @(negedge clk);
            chk(fault_bits == expv, "R12 random sticky", fault_bits, expv);
            chk(alert_n == ~|(fault_bits & ~alert_mask), "R13 random alert", alert_n,
                ~|(fault_bits & ~alert_mask));
            chk(!(pgood && hs_off), "R2 random pgood", pgood, 0);
            fl = '0;
            for (int b = 0; b < 11; b++) if (b != 9) fl[b] = ($urandom % 40) == 0;
            {flt_ot, flt_oc, wrn_oc, evt_noc, flt_ov_trk, flt_ov_fix} =
                {fl[0], fl[1], fl[2], fl[3], fl[4], fl[5]};
            {wrn_ov, flt_uv_trk, wrn_uv, flt_vin_ov} = {fl[6], fl[7], fl[8], fl[10]};
            clear_faults = ($urandom % 25) == 0;
            enable = (c % 150) != 0;
            if (c % 200 == 0) begin
                alert_mask = 11'($urandom);
                cfg_ov_mode = 2'($urandom);
                cfg_uv_mode = 2'($urandom);
                cfg_ot_restart = 1'($urandom);
            end
            #1;
            expv = exp_next(fault_bits, clear_faults, !hs_off, pgood, hs_off && ls_hold, fl);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule